// File: doc/BRIEF.md
# Two-Stage Serial Clock Rate Generator

This block derives the serial clock for an SPI engine from the module clock. A 16-bit clock select word carries a prescaler field (1 to 32) and a coded power-of-two divider field. The total ratio from module clock to serial clock is the prescaler value times the divider ratio, from 1 up to 1024.

The serial engine gets three outputs. The first is a serial clock level that idles low. The other two are single-cycle strobes: one marks the start of the high phase and one marks the start of the low phase, and the engine times its shift and sample edges on them.

Clearing the enable input stops the clock at once and restarts the count. A new clock select value is picked up only when a period ends, so no shortened pulse can appear.

Top module: `spi_rate_gen`

## Requirements
- R1: The prescaler value P is `cfg_i[12:8]` plus one, so field values 0 to 31 give P from 1 to 32.
- R2: The divider code `cfg_i[2:0]` selects the divider ratio D as follows: code 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16, 4 gives 32, and 7 gives 1.
- R3: Divider codes 5 and 6 behave as divide-by-1.
- R4: While enabled, `rise_o` pulses once every N = P*D cycles. The first pulse comes in the cycle after the first rising clock edge at which `en_i` is sampled high.
- R5: In each period `sck_o` is high for floor(N/2) cycles, starting in the `rise_o` cycle, and low for the remaining ceil(N/2) cycles. `fall_o` pulses in the first low cycle, floor(N/2) cycles after `rise_o`. With an odd N the high phase is therefore one cycle shorter than the low phase.
- R6: With N = 1, `sck_o` stays low and both `rise_o` and `fall_o` are high in every enabled cycle.
- R7: During reset, and in the cycle after `en_i` is sampled low, `sck_o`, `rise_o` and `fall_o` are all low. Raising `en_i` again restarts the period from its first cycle.
- R8: A change of `cfg_i` while running leaves the current period untouched. The new ratio applies from the next `rise_o`.
- R9: Bits of `cfg_i` outside 12:8 and 2:0 have no effect on the output timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Serial clock output enable |
| cfg_i | input | 16 | Clock select word (prescaler field and divider code) |
| sck_o | output | 1 | Serial clock level, idle low |
| rise_o | output | 1 | Strobe for the start of the high phase (period start) |
| fall_o | output | 1 | Strobe for the start of the low phase |

## Verification
The bench measures the period, the high time and the offset of `fall_o` for every divider code, including the reserved codes 5 and 6. A wrong decode would show up as a mis-sized period, and a slip at the upper edge would make the 32 by 32 case collapse or wrap instead of giving 1024. Odd ratios such as 3 and 5 catch a split that rounds the high phase up. Divide-by-1 catches a design that stalls or toggles the serial clock level when it should stay low. A mid-period disable must silence every output in the next cycle, and a mid-period change of the select word must not shorten the running period. A design that reloads at once would show `rise_o` too early.

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int CFG_W   = 16,
  parameter int PRE_W   = 5,
  parameter int PRE_LSB = 8,
  parameter int CODE_W  = 3,
  parameter int MAX_SH  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int CNT_W = PRE_W + MAX_SH + 1;

  logic [PRE_W-1:0]  pre_f;
  logic [CODE_W-1:0] code_f;
  logic [2:0]        shamt;
  logic [CNT_W-1:0]  cfg_n, act_n, cnt, hi_len;
  logic              run;

  assign pre_f  = cfg_i[PRE_LSB +: PRE_W];
  assign code_f = cfg_i[CODE_W-1:0];
  assign shamt  = (code_f <= CODE_W'(MAX_SH - 1)) ? 3'(code_f + 1'b1) : 3'd0;
  assign cfg_n  = (CNT_W'(pre_f) + 1'b1) << shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run   <= 1'b0;
      cnt   <= '0;
      act_n <= CNT_W'(1);
    end else if (!en_i) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!run || cnt == act_n - 1'b1) begin
      run   <= 1'b1;
      cnt   <= '0;
      act_n <= cfg_n;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hi_len = act_n >> 1;
  assign sck_o  = run && (cnt < hi_len);
  assign rise_o = run && (cnt == '0);
  assign fall_o = run && (cnt == hi_len);

  assert_idle_after_disable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sck_o && !rise_o && !fall_o));
  assert_count_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt < act_n));
  assert_rise_with_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> rise_o);
  assert_fall_with_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sck_o) && run) |-> fall_o);
  assert_both_strobes_only_div1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && fall_o) |-> (act_n == CNT_W'(1) && !sck_o));
  assert_ratio_held_in_period_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && !rise_o) |-> $stable(act_n));
endmodule

// File: tb/spi_rate_gen_tb.sv
module spi_rate_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] cfg = 16'h0000;
  logic        sck, rise, fall;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  spi_rate_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_i(cfg),
    .sck_o(sck), .rise_o(rise), .fall_o(fall)
  );

  localparam int NV = 12;
  // {cfg, expected total ratio}
  localparam logic [15:0] VCFG [NV] = '{16'h0007, 16'h0000, 16'h0001, 16'h0102,
                                        16'h0203, 16'h1F04, 16'h0405, 16'h0206,
                                        16'h1F07, 16'hE0F8, 16'h0104, 16'h0600};
  localparam int VN [NV] = '{1, 2, 4, 16, 48, 1024, 5, 3, 32, 2, 64, 14};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // from a rise cycle, measure period, high cycles and fall offset
  task automatic measure(output int per, output int hi, output int fpos);
    int k = 0;
    hi = 0;
    fpos = -1;
    do begin
      if (sck) hi++;
      if (fall && fpos < 0) fpos = k;
      @(negedge clk);
      k++;
    end while (!rise && k < 3000);
    per = k;
  endtask

  task automatic start(input logic [15:0] c);
    @(negedge clk);
    en = 1'b0;
    cfg = c;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int per, hi, fp;
    repeat (3) @(negedge clk);
    // reset state, R7
    chk("R7 reset sck", int'(sck), 0);
    chk("R7 reset rise", int'(rise), 0);
    chk("R7 reset fall", int'(fall), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R7 held in reset rise", int'(rise), 0);
    en = 1'b0;
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      start(VCFG[i]);
      chk($sformatf("R4 first rise cfg=%h", VCFG[i]), int'(rise), 1);
      measure(per, hi, fp);
      chk($sformatf("R1/R2/R3/R4 period cfg=%h", VCFG[i]), per, VN[i]);
      chk($sformatf("R5/R6 high time cfg=%h", VCFG[i]), hi, VN[i] / 2);
      chk($sformatf("R5/R6 fall offset cfg=%h", VCFG[i]), fp, VN[i] / 2);
    end

    // R6 steady every-cycle strobes
    start(16'h0007);
    for (int k = 0; k < 4; k++) begin
      chk("R6 div1 strobes", int'(rise && fall && !sck), 1);
      @(negedge clk);
    end

    // R7 mid-period disable and restart
    start(16'h0102);
    repeat (3) @(negedge clk);
    chk("R7 sck high before disable", int'(sck), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R7 sck after disable", int'(sck), 0);
    chk("R7 strobes after disable", int'(rise || fall), 0);
    repeat (20) @(negedge clk);
    chk("R7 silent while disabled", int'(sck || rise || fall), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R7 restart rise", int'(rise), 1);
    measure(per, hi, fp);
    chk("R7 restart full period", per, 16);

    // R8 change mid-period
    start(16'h0102);
    repeat (4) @(negedge clk);
    cfg = 16'h0000;
    // 4 cycles already elapsed; rest of the 16-cycle period must remain
    begin
      int k = 4;
      while (!rise && k < 100) begin
        @(negedge clk);
        k++;
      end
      chk("R8 old period kept", k, 16);
    end
    measure(per, hi, fp);
    chk("R8 new period applied", per, 2);
    chk("R8 new high time", hi, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule